// File: doc/BRIEF.md
# Four-Phase File Register Executor

This block executes two byte-wide file-register operations: bitwise complement of a data-memory byte, and an unsigned equality compare of a data-memory byte against the working register that asks the surrounding core to skip the next instruction. Every instruction occupies one instruction cycle of four clocks. The phases run in a fixed order: decode, operand read, process and write-back. A two-bit phase output lets the surrounding core fetch in step with the executor.

The instruction word is sampled in the decode phase, together with the bank select value and the working register. From the eight-bit register field and the bank-mode bit, the block forms a 12-bit address into a 4096-byte data memory that has a synchronous read port. It reads the operand and computes the result. The complement result goes either to the working register, through a write strobe, or back to the same memory byte. The negative and zero flags come from the complement result. The compare only raises a skip request. Any other opcode passes through the four phases and has no effect.

Top module: `fr_exec`

## Requirements
- R1: While reset is applied, and until the first instruction completes, the phase output is 0 and the negative and zero flags are 0. In that time there is no memory read strobe, no memory write, no working-register write and no skip request. A reset that arrives in the middle of an instruction cancels its write and its flag update.
- R2: The phase output steps 0 (decode), 1 (read), 2 (process), 3 (write) and then returns to 0, advancing by one on every clock.
- R3: The instruction word, the bank select value and the working register are sampled during phase 0 and must stay stable until phase 3 ends. For a supported opcode the memory read strobe is asserted in phase 1 only, with the operand address on the address output.
- R4: The address is formed as follows. With bank-mode bit 8 equal to 0, register field f (bits 7:0) values 00h to 5Fh map to addresses 000h to 05Fh, and f values 60h to FFh map to F60h to FFFh. With bit 8 equal to 1, the address is the low 4 bits of the bank select value followed by f.
- R5: Complement is encoded as bits[15:10] = 000111. When destination bit 9 is 0, the complement of the operand is written back to the addressed byte in phase 3, and the working register is not written. For example, 13h becomes ECh.
- R6: When a complement instruction has destination bit 9 equal to 1, the complement is driven on the working-register write port with its strobe in phase 3, and memory is not written.
- R7: After a complement, the negative flag equals bit 7 of the result and the zero flag is 1 exactly when the result is 00h. Both flags are visible from the next phase 0.
- R8: Compare-and-skip is encoded as bits[15:9] = 0110001. When the operand equals the working register (unsigned), the skip request is high during phase 3. The instruction writes nothing and leaves both flags unchanged.
- R9: For a compare whose operand differs from the working register, the skip request stays low and the instruction writes nothing.
- R10: Any other opcode (for example 1800h or 6400h) produces no write, no skip request and no flag change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; four clocks per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_i | input | 16 | Instruction word, sampled in phase 0 |
| w_i | input | 8 | Current working register value |
| bank_i | input | 4 | Bank select value for banked addressing |
| phase_o | output | 2 | Current phase: 0 decode, 1 read, 2 process, 3 write |
| mem_addr_o | output | 12 | Data memory address |
| mem_rd_en_o | output | 1 | Memory read strobe (data returned on the next clock) |
| mem_rd_data_i | input | 8 | Memory read data |
| mem_wr_en_o | output | 1 | Memory write strobe |
| mem_wr_data_o | output | 8 | Memory write data |
| w_wr_en_o | output | 1 | Working-register write strobe |
| w_wr_data_o | output | 8 | Working-register write data |
| skip_o | output | 1 | Skip request for the next instruction |
| n_flag_o | output | 1 | Negative flag |
| z_flag_o | output | 1 | Zero flag |

## Verification
The hardest case to reach is an instruction that must leave the flags untouched: a compare, or an unsupported opcode, that runs right after a complement which set the flags to a non-reset value. It has to be shown that the flags hold their value and are not merely reset. The vector table therefore places complements with negative or zero results directly before compares and unsupported opcodes, and the expected flags are carried forward from one vector to the next. A reset asserted in the process phase of a complement checks that a write which has been decoded but not yet committed is cancelled.

// File: rtl/fr_pkg.sv
package fr_pkg;

  typedef enum logic [1:0] {
    PH_DECODE = 2'd0,
    PH_READ   = 2'd1,
    PH_PROC   = 2'd2,
    PH_WRITE  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_CPL   = 2'd1,
    OP_CMPEQ = 2'd2
  } op_e;

  localparam logic [5:0] CPL_CODE   = 6'b000111;
  localparam logic [6:0] CMPEQ_CODE = 7'b0110001;

endpackage

// File: rtl/fr_phase_seq.sv
module fr_phase_seq
  import fr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    unique case (phase_q)
      PH_DECODE: phase_d = PH_READ;
      PH_READ:   phase_d = PH_PROC;
      PH_PROC:   phase_d = PH_WRITE;
      default:   phase_d = PH_DECODE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_DECODE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/fr_decode.sv
module fr_decode
  import fr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int F_W     = 8,
  parameter int BANK_W  = 4,
  parameter int SPLIT   = 'h60,
  localparam int ADDR_W = F_W + BANK_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [BANK_W-1:0]  bank_i,
  output op_e                op_o,
  output logic               to_w_o,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [F_W-1:0] f_field;
  logic           banked;

  assign f_field = instr_i[F_W-1:0];
  assign banked  = instr_i[F_W];
  assign to_w_o  = instr_i[F_W+1];

  always_comb begin
    if (instr_i[INSTR_W-1 -: 6] == CPL_CODE)        op_o = OP_CPL;
    else if (instr_i[INSTR_W-1 -: 7] == CMPEQ_CODE) op_o = OP_CMPEQ;
    else                                             op_o = OP_NONE;
  end

  always_comb begin
    if (banked)                       addr_o = {bank_i, f_field};
    else if (int'(f_field) < SPLIT)   addr_o = {{BANK_W{1'b0}}, f_field};
    else                              addr_o = {{BANK_W{1'b1}}, f_field};
  end

endmodule

// File: rtl/fr_alu.sv
module fr_alu
  import fr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] w_i,
  output logic [DATA_W-1:0] result_o,
  output logic              equal_o
);

  always_comb begin
    result_o = '0;
    equal_o  = 1'b0;
    unique case (op_i)
      OP_CPL:   result_o = ~opnd_i;
      OP_CMPEQ: equal_o  = (opnd_i == w_i);
      default:  ;
    endcase
  end

endmodule

// File: rtl/fr_exec.sv
module fr_exec
  import fr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 4,
  parameter int SPLIT   = 'h60,
  localparam int ADDR_W = DATA_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  w_i,
  input  logic [BANK_W-1:0]  bank_i,
  output logic [1:0]         phase_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_rd_en_o,
  input  logic [DATA_W-1:0]  mem_rd_data_i,
  output logic               mem_wr_en_o,
  output logic [DATA_W-1:0]  mem_wr_data_o,
  output logic               w_wr_en_o,
  output logic [DATA_W-1:0]  w_wr_data_o,
  output logic               skip_o,
  output logic               n_flag_o,
  output logic               z_flag_o
);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_e phase;

  fr_phase_seq i_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .phase_o (phase)
  );

  op_e               dec_op;
  logic              dec_to_w;
  logic [ADDR_W-1:0] dec_addr;

  fr_decode #(
    .INSTR_W (INSTR_W),
    .F_W     (DATA_W),
    .BANK_W  (BANK_W),
    .SPLIT   (SPLIT)
  ) i_dec (
    .instr_i (instr_i),
    .bank_i  (bank_i),
    .op_o    (dec_op),
    .to_w_o  (dec_to_w),
    .addr_o  (dec_addr)
  );

  // decoded-instruction registers, loaded in the decode phase
  op_e               op_q,   op_d;
  logic              to_w_q, to_w_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  // process-phase results
  logic [DATA_W-1:0] res_q, res_d;
  logic              eq_q,  eq_d;
  logic [DATA_W-1:0] alu_res;
  logic              alu_eq;

  // status flags
  logic n_q, n_d;
  logic z_q, z_d;

  fr_alu #(
    .DATA_W (DATA_W)
  ) i_alu (
    .op_i     (op_q),
    .opnd_i   (mem_rd_data_i),
    .w_i      (w_i),
    .result_o (alu_res),
    .equal_o  (alu_eq)
  );

  logic ld_dec, ld_res, ld_flags;

  assign ld_dec   = (phase == PH_DECODE);
  assign ld_res   = (phase == PH_PROC);
  assign ld_flags = (phase == PH_WRITE) && (op_q == OP_CPL);

  always_comb begin
    op_d   = op_q;
    to_w_d = to_w_q;
    addr_d = addr_q;
    res_d  = res_q;
    eq_d   = eq_q;
    n_d    = n_q;
    z_d    = z_q;
    if (ld_dec) begin
      op_d   = dec_op;
      to_w_d = dec_to_w;
      addr_d = dec_addr;
    end
    if (ld_res) begin
      res_d = alu_res;
      eq_d  = alu_eq;
    end
    if (ld_flags) begin
      n_d = res_q[DATA_W-1];
      z_d = (res_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q   <= OP_NONE;
      to_w_q <= 1'b0;
      eq_q   <= 1'b0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
    end else begin
      op_q   <= op_d;
      to_w_q <= to_w_d;
      eq_q   <= eq_d;
      n_q    <= n_d;
      z_q    <= z_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q <= addr_d;
    res_q  <= res_d;
  end

  logic in_write;
  assign in_write = (phase == PH_WRITE);

  assign phase_o       = phase;
  assign mem_addr_o    = addr_q;
  assign mem_rd_en_o   = (phase == PH_READ) && (op_q != OP_NONE);
  assign mem_wr_en_o   = in_write && (op_q == OP_CPL) && !to_w_q;
  assign mem_wr_data_o = res_q;
  assign w_wr_en_o     = in_write && (op_q == OP_CPL) && to_w_q;
  assign w_wr_data_o   = res_q;
  assign skip_o        = in_write && (op_q == OP_CMPEQ) && eq_q;
  assign n_flag_o      = n_q;
  assign z_flag_o      = z_q;

endmodule

// File: rtl/fr_exec_chk.sv
module fr_exec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] phase,
  input logic       mem_rd_en,
  input logic       mem_wr_en,
  input logic       w_wr_en,
  input logic       skip,
  input logic       n_flag,
  input logic       z_flag
);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == 2'($past(phase) + 2'd1));

  // R3
  read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> phase == 2'd1);

  // R5
  write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || w_wr_en || skip) |-> phase == 2'd3);

  // R6
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && w_wr_en));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3 |=> $stable({n_flag, z_flag}));

  // R8
  skip_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !mem_wr_en && !w_wr_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !mem_rd_en && !mem_wr_en && !w_wr_en && !skip && phase == 2'd0);

endmodule

bind fr_exec fr_exec_chk i_fr_exec_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .phase     (phase_o),
  .mem_rd_en (mem_rd_en_o),
  .mem_wr_en (mem_wr_en_o),
  .w_wr_en   (w_wr_en_o),
  .skip      (skip_o),
  .n_flag    (n_flag_o),
  .z_flag    (z_flag_o)
);

// File: tb/test_fr_exec.sv
`timescale 1ns/1ps
module test_fr_exec;

  logic        clk;
  logic        rst_n;
  logic [15:0] instr;
  logic [7:0]  w;
  logic [3:0]  bank;
  logic [1:0]  phase;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_data;
  logic        mem_wr_en;
  logic [7:0]  mem_wr_data;
  logic        w_wr_en;
  logic [7:0]  w_wr_data;
  logic        skip;
  logic        n_flag;
  logic        z_flag;

  int checks = 0;
  int errors = 0;
  logic exp_n = 1'b0;
  logic exp_z = 1'b0;

  logic [7:0] mem [4096];

  fr_exec i_fr_exec (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr),
    .w_i           (w),
    .bank_i        (bank),
    .phase_o       (phase),
    .mem_addr_o    (mem_addr),
    .mem_rd_en_o   (mem_rd_en),
    .mem_rd_data_i (mem_rd_data),
    .mem_wr_en_o   (mem_wr_en),
    .mem_wr_data_o (mem_wr_data),
    .w_wr_en_o     (w_wr_en),
    .w_wr_data_o   (w_wr_data),
    .skip_o        (skip),
    .n_flag_o      (n_flag),
    .z_flag_o      (z_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // data memory model: synchronous read, synchronous write
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector: instr, w, bank, memval, addr, chk_addr, kind(0 none,1 mem,2 W,3 skip), data
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {16'h1C20, 8'h00, 4'h0, 8'h13, 12'h020, 1'b1, 2'd1, 8'hEC},
    {16'h1E60, 8'h55, 4'h7, 8'hFF, 12'hF60, 1'b1, 2'd2, 8'h00},
    {16'h62FF, 8'h3C, 4'h0, 8'h3C, 12'hFFF, 1'b1, 2'd3, 8'h00},
    {16'h1F5F, 8'h00, 4'h5, 8'h80, 12'h55F, 1'b1, 2'd2, 8'h7F},
    {16'h1C5F, 8'h00, 4'h9, 8'h00, 12'h05F, 1'b1, 2'd1, 8'hFF},
    {16'h6312, 8'h3C, 4'hA, 8'h3D, 12'hA12, 1'b1, 2'd0, 8'h00},
    {16'h1800, 8'h00, 4'h0, 8'h11, 12'h000, 1'b0, 2'd0, 8'h00},
    {16'h1DA7, 8'h00, 4'hC, 8'h5A, 12'hCA7, 1'b1, 2'd1, 8'hA5},
    {16'h6380, 8'h00, 4'h3, 8'h00, 12'h380, 1'b1, 2'd3, 8'h00},
    {16'h6400, 8'h00, 4'h0, 8'h22, 12'h000, 1'b0, 2'd0, 8'h00},
    {16'h1C7F, 8'h00, 4'h0, 8'h0F, 12'hF7F, 1'b1, 2'd1, 8'hF0}
  };

  // runs one instruction starting at a negedge in phase 0; ends at the next phase 0
  task automatic run_vec(input logic [58:0] v);
    logic [15:0] vi;   logic [7:0] vw;  logic [3:0] vb; logic [7:0] vm;
    logic [11:0] va;   logic ca;        logic [1:0] vk; logic [7:0] vd;
    bit phase_ok, rd_ok, stray, mw, ww, sk;
    logic [7:0] mwd, wwd;
    {vi, vw, vb, vm, va, ca, vk, vd} = v;
    mem[va] = vm;
    instr = vi; w = vw; bank = vb;
    phase_ok = 1; rd_ok = 1; stray = 0; mw = 0; ww = 0; sk = 0; mwd = 0; wwd = 0;
    for (int c = 0; c < 4; c++) begin
      #1;
      if (phase != 2'(c)) phase_ok = 0;
      if (c == 1 && ca && !(mem_rd_en && mem_addr == va)) rd_ok = 0;
      if (c != 1 && mem_rd_en) rd_ok = 0;
      if (c != 3 && (mem_wr_en || w_wr_en || skip)) stray = 1;
      if (c == 3) begin
        mw = mem_wr_en; ww = w_wr_en; sk = skip; mwd = mem_wr_data; wwd = w_wr_data;
      end
      @(negedge clk);
    end
    #1;
    check(phase_ok && phase == 2'd0, "R2 phase sequence", phase, 0);
    check(rd_ok, "R3/R4 read strobe and address", mem_addr, va);
    check(!stray, "R5 no action outside write phase", stray, 0);
    case (vk)
      2'd1: begin
        check(mw && !ww && !sk && mwd == vd, "R5 write back to memory", {mw, ww, sk, mwd}, {3'b100, vd});
        check(mem[va] == vd, "R5 memory content", mem[va], vd);
      end
      2'd2: check(ww && !mw && !sk && wwd == vd, "R6 write to W", {mw, ww, sk, wwd}, {3'b010, vd});
      2'd3: check(sk && !mw && !ww, "R8 skip on equal", {mw, ww, sk}, 3'b001);
      default: check(!sk && !mw && !ww,
                     (vi[15:9] == 7'b0110001) ? "R9 no skip on unequal" : "R10 unsupported opcode inert",
                     {mw, ww, sk}, 3'b000);
    endcase
    if (vk == 2'd1 || vk == 2'd2) begin
      exp_n = vd[7];
      exp_z = (vd == 8'h00);
      check({n_flag, z_flag} == {exp_n, exp_z}, "R7 flags from complement", {n_flag, z_flag}, {exp_n, exp_z});
    end else begin
      check({n_flag, z_flag} == {exp_n, exp_z}, "R8/R10 flags unchanged", {n_flag, z_flag}, {exp_n, exp_z});
    end
  endtask

  initial begin
    bit quiet;
    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    mem_rd_data = 8'h00;
    instr = 16'h0000; w = 8'h00; bank = 4'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(phase == 2'd0 && !n_flag && !z_flag, "R1 reset phase and flags", {phase, n_flag, z_flag}, 0);
    check(!mem_rd_en && !mem_wr_en && !w_wr_en && !skip, "R1 reset strobes", {mem_rd_en, mem_wr_en, w_wr_en, skip}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    quiet = 1;
    // synchronous release: hold phase 0 for the synchroniser cycles
    for (int i = 0; i < 2; i++) begin
      #1;
      if (phase != 2'd0 || mem_wr_en || w_wr_en || skip) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R1 quiet during reset release", quiet, 1);
    while (phase != 2'd0) @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R1: reset during the process phase cancels the write and clears flags
    mem[12'h044] = 8'h3C;
    instr = 16'h1C44; w = 8'h00; bank = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!mem_wr_en && !n_flag && !z_flag, "R1 mid-instruction reset", {mem_wr_en, n_flag, z_flag}, 0);
    repeat (3) @(negedge clk);
    check(mem[12'h044] == 8'h3C, "R1 cancelled write", mem[12'h044], 8'h3C);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_n = 1'b0; exp_z = 1'b0;
    while (phase != 2'd0) @(negedge clk);
    // after the reset, a complement of 13h gives ECh (R5)
    run_vec({16'h1C21, 8'h00, 4'h0, 8'h13, 12'h021, 1'b1, 2'd1, 8'hEC});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule